// File: doc/BRIEF.md
# Wormhole Virtual-Channel Output Stage

This block is the output-side switching stage of a wormhole router in an on-chip network. Packets reach it as link-width flits. Each flit carries a virtual-channel number and two marker bits, one for the first flit of a packet and one for the last. Every virtual channel has its own small flit queue, so a packet that stalls on one channel leaves the others free to use the single outgoing link.

A strict fixed-priority arbiter decides which channel drives the link, and channel 0 has the highest priority. A channel that sends a first flit keeps the link until it sends its last flit, so the flits of a packet are never interleaved with those of another packet on the link. Each channel also has a credit counter for the downstream buffer. A flit leaves only while its channel holds a credit, and the downstream side returns credits one pulse at a time.

Top module: `wh_vc_port`

## Requirements
- R1: After reset, `out_valid` is 0, every bit of `in_ready` is 1, every bit of `overflow` is 0, and each channel holds CREDIT_MAX credits.
- R2: A flit written while its channel's queue has room is stored. If that channel is free to send, the flit appears on the output two clock edges after it is presented, with the same channel number, data, first-flit marker and last-flit marker.
- R3: `in_ready[v]` is 0 while channel v holds FIFO_DEPTH flits. A write to a full channel is dropped and never reaches the output, and it sets `overflow[v]`, which stays set until reset.
- R4: The flits of one channel leave in the order in which they were written.
- R5: At a packet boundary, the lowest-numbered channel that has a flit and a credit wins the link.
- R6: After a channel sends a flit with `in_head`=1 and `in_tail`=0, no other channel sends until that channel has sent a flit with `in_tail`=1. While the owning channel is stalled, the link stays idle, even if a higher-priority channel is ready.
- R7: A channel sends only while its credit count is nonzero. Each flit sent uses one credit. A `credit_ret[v]` pulse adds one credit, and the flit it frees leaves two edges after the pulse is presented.
- R8: A flit with both `in_head`=1 and `in_tail`=1 is a whole packet and does not reserve the link.
- R9: `out_valid` is 0 in every cycle that follows an edge at which no flit was sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Flit write strobe |
| in_vc | input | $clog2(NUM_VC) | Channel of the incoming flit |
| in_head | input | 1 | Incoming flit is the first flit of its packet |
| in_tail | input | 1 | Incoming flit is the last flit of its packet |
| in_data | input | FLIT_W | Incoming flit payload |
| in_ready | output | NUM_VC | Per-channel queue has room |
| credit_ret | input | NUM_VC | Per-channel credit return pulse |
| out_valid | output | 1 | Output link carries a flit |
| out_vc | output | $clog2(NUM_VC) | Channel of the outgoing flit |
| out_head | output | 1 | First-flit marker of the outgoing flit |
| out_tail | output | 1 | Last-flit marker of the outgoing flit |
| out_data | output | FLIT_W | Outgoing flit payload |
| overflow | output | NUM_VC | Sticky per-channel dropped-write flag |

## Verification
A stored flit leaves two edges after it is written: one edge fills the queue, and the next edge selects it and registers the output. A credit pulse likewise frees a stalled flit two edges later. The bench samples on falling edges and checks `out_valid` as 0 one sample after the stimulus and as 1 on the next. The overflow flag and `in_ready` change on the edge of the write, so they are read on the falling edge that directly follows it. For the ordering checks, the bench withholds credits so that flits build up in the queues, returns the credits in a chosen pattern, and compares the order of the logged output flits against the order it computes from priority and packet ownership.

// File: rtl/wh_vc_pkg.sv
package wh_vc_pkg;

  // Index of the lowest set bit; 0 when no bit is set.
  function automatic int first_set(input logic [31:0] v);
    int idx;
    idx = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) idx = i;
    end
    return idx;
  endfunction

  // Next credit count: one back per return pulse, one spent per send, capped.
  function automatic int credit_step(input int cur, input logic give,
                                     input logic take, input int cap);
    int n;
    n = cur + (give ? 1 : 0);
    if (take && n > 0) n = n - 1;
    if (n > cap) n = cap;
    return n;
  endfunction

endpackage

// File: rtl/wh_vc_fifo.sv
module wh_vc_fifo #(
  parameter int W     = 34,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/wh_vc_credit.sv
module wh_vc_credit #(
  parameter int MAX = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic give,
  input  logic take,
  output logic has_credit
);
  import wh_vc_pkg::*;
  localparam int CW = $clog2(MAX + 1);

  logic [CW-1:0] cnt;

  assign has_credit = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= CW'(MAX);
    else        cnt <= CW'(credit_step(int'(cnt), give, take, MAX));
  end
endmodule

// File: rtl/wh_vc_arb.sv
module wh_vc_arb #(
  parameter int N  = 4,
  parameter int VW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  elig,
  input  logic          sel_head,
  input  logic          sel_tail,
  output logic          grant_valid,
  output logic [VW-1:0] grant_vc,
  output logic          locked,
  output logic [VW-1:0] locked_vc
);
  import wh_vc_pkg::*;

  always_comb begin
    if (locked) begin
      grant_valid = elig[locked_vc];
      grant_vc    = locked_vc;
    end else begin
      grant_valid = |elig;
      grant_vc    = VW'(first_set(32'(elig)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked    <= 1'b0;
      locked_vc <= '0;
    end else if (grant_valid) begin
      if (sel_tail) begin
        locked <= 1'b0;
      end else if (sel_head) begin
        locked    <= 1'b1;
        locked_vc <= grant_vc;
      end
    end
  end
endmodule

// File: rtl/wh_vc_port.sv
module wh_vc_port #(
  parameter int NUM_VC     = 4,
  parameter int FLIT_W     = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int CREDIT_MAX = 4,
  localparam int VCW = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [VCW-1:0]    in_vc,
  input  logic              in_head,
  input  logic              in_tail,
  input  logic [FLIT_W-1:0] in_data,
  output logic [NUM_VC-1:0] in_ready,
  input  logic [NUM_VC-1:0] credit_ret,
  output logic              out_valid,
  output logic [VCW-1:0]    out_vc,
  output logic              out_head,
  output logic              out_tail,
  output logic [FLIT_W-1:0] out_data,
  output logic [NUM_VC-1:0] overflow
);
  localparam int EW = FLIT_W + 2;

  // Named internal events, visible to the bound checker.
  logic [NUM_VC-1:0] vc_full, vc_empty, has_credit, elig;
  logic [EW-1:0]     fifo_q [NUM_VC];
  logic [EW-1:0]     sel_flit;
  logic              send_fire;
  logic [VCW-1:0]    send_vc;
  logic              locked;
  logic [VCW-1:0]    locked_vc;

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    logic wr_hit, rd_hit;
    assign wr_hit = in_valid && (in_vc == VCW'(v));
    assign rd_hit = send_fire && (send_vc == VCW'(v));

    wh_vc_fifo #(.W(EW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (wr_hit),
      .pop   (rd_hit),
      .wdata ({in_head, in_tail, in_data}),
      .rdata (fifo_q[v]),
      .full  (vc_full[v]),
      .empty (vc_empty[v])
    );

    wh_vc_credit #(.MAX(CREDIT_MAX)) u_credit (
      .clk        (clk),
      .rst_n      (rst_n),
      .give       (credit_ret[v]),
      .take       (rd_hit),
      .has_credit (has_credit[v])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  overflow[v] <= 1'b0;
      else if (wr_hit && vc_full[v]) overflow[v] <= 1'b1;
    end
  end

  assign elig     = ~vc_empty & has_credit;
  assign in_ready = ~vc_full;
  assign sel_flit = fifo_q[send_vc];

  wh_vc_arb #(.N(NUM_VC), .VW(VCW)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .elig        (elig),
    .sel_head    (sel_flit[EW-1]),
    .sel_tail    (sel_flit[EW-2]),
    .grant_valid (send_fire),
    .grant_vc    (send_vc),
    .locked      (locked),
    .locked_vc   (locked_vc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_vc    <= '0;
      out_head  <= 1'b0;
      out_tail  <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= send_fire;
      if (send_fire) begin
        out_vc   <= send_vc;
        out_head <= sel_flit[EW-1];
        out_tail <= sel_flit[EW-2];
        out_data <= sel_flit[FLIT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/wh_vc_port_chk.sv
module wh_vc_port_chk #(
  parameter int NUM_VC = 4,
  parameter int VCW    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [VCW-1:0]    in_vc,
  input logic [NUM_VC-1:0] in_ready,
  input logic [NUM_VC-1:0] overflow,
  input logic              send_fire,
  input logic [VCW-1:0]    send_vc,
  input logic [NUM_VC-1:0] has_credit,
  input logic              locked,
  input logic [VCW-1:0]    locked_vc,
  input logic              out_valid
);

  // R1: reset leaves the link idle and no overflow flag set
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && overflow == '0));

  // R3: a write refused for lack of room raises that channel's flag
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready[in_vc]) |=> overflow[$past(in_vc)]);

  // R3: overflow flags never clear outside reset
  p_overflow_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((overflow & $past(overflow)) == $past(overflow)));

  // R7: a flit leaves only from a channel holding a credit
  p_credit_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    send_fire |-> has_credit[send_vc]);

  // R6: ownership of the link is released only by a send
  p_hold_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !send_fire) |=> (locked && locked_vc == $past(locked_vc)));

  // R2: every selection shows up on the link one edge later
  p_send_shows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    send_fire |=> out_valid);

  // R9: no selection, no flit on the link
  p_idle_link_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !send_fire |=> !out_valid);

endmodule

bind wh_vc_port wh_vc_port_chk #(.NUM_VC(NUM_VC), .VCW(VCW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_vc      (in_vc),
  .in_ready   (in_ready),
  .overflow   (overflow),
  .send_fire  (send_fire),
  .send_vc    (send_vc),
  .has_credit (has_credit),
  .locked     (locked),
  .locked_vc  (locked_vc),
  .out_valid  (out_valid)
);

// File: tb/wh_vc_port_test.sv
`timescale 1ns/1ps
module wh_vc_port_test;
  localparam int NV = 4;
  localparam int FW = 32;
  localparam int DEP = 4;
  localparam int CRD = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [1:0]    in_vc = '0;
  logic          in_head = 1'b0, in_tail = 1'b0;
  logic [FW-1:0] in_data = '0;
  logic [NV-1:0] in_ready;
  logic [NV-1:0] credit_ret = '0;
  logic          out_valid;
  logic [1:0]    out_vc;
  logic          out_head, out_tail;
  logic [FW-1:0] out_data;
  logic [NV-1:0] overflow;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wh_vc_port #(.NUM_VC(NV), .FLIT_W(FW), .FIFO_DEPTH(DEP), .CREDIT_MAX(CRD)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vc(in_vc),
    .in_head(in_head), .in_tail(in_tail), .in_data(in_data),
    .in_ready(in_ready), .credit_ret(credit_ret), .out_valid(out_valid),
    .out_vc(out_vc), .out_head(out_head), .out_tail(out_tail),
    .out_data(out_data), .overflow(overflow)
  );

  // Output log, filled shortly after each rising edge.
  int          log_n = 0;
  logic [1:0]  log_vc [64];
  logic [31:0] log_d  [64];
  logic        log_h  [64];
  logic        log_t  [64];

  always @(posedge clk) begin
    #1;
    if (rst_n && out_valid && log_n < 64) begin
      log_vc[log_n] = out_vc;
      log_d[log_n]  = out_data;
      log_h[log_n]  = out_head;
      log_t[log_n]  = out_tail;
      log_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
    chk(act === exp, req, what, act, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; credit_ret = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    log_n = 0;
  endtask

  task automatic push(input int vc, input bit h, input bit t, input logic [31:0] d);
    in_valid = 1'b1; in_vc = 2'(vc); in_head = h; in_tail = t; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic ret(input logic [NV-1:0] mask);
    credit_ret = mask;
    @(negedge clk);
    credit_ret = '0;
  endtask

  // Spend every credit of one channel with whole-packet flits (R7, R8).
  task automatic drain(input int vc);
    for (int i = 0; i < CRD; i++) push(vc, 1'b1, 1'b1, 32'hDEAD_0000 + 32'(i));
    idle(4);
    chk_eq("R7", "flits sent on full credit", 64'(log_n), 64'(CRD));
    log_n = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    do_reset();
    chk_eq("R1", "out_valid", 64'(out_valid), 64'd0);
    chk_eq("R1", "in_ready", 64'(in_ready), 64'hF);
    chk_eq("R1", "overflow", 64'(overflow), 64'd0);

    // R2 and R9: latency of a single flit
    push(2, 1'b1, 1'b1, 32'hA5A5_0002);
    chk_eq("R2", "not yet on link", 64'(out_valid), 64'd0);
    idle(1);
    chk_eq("R2", "valid second edge", 64'(out_valid), 64'd1);
    chk_eq("R2", "vc", 64'(out_vc), 64'd2);
    chk_eq("R2", "data", 64'(out_data), 64'hA5A5_0002);
    chk_eq("R2", "markers", 64'({out_head, out_tail}), 64'b11);
    idle(1);
    chk_eq("R9", "link idle after", 64'(out_valid), 64'd0);

    // R7: credit gating and return latency
    do_reset();
    drain(2);
    push(2, 1'b1, 1'b1, 32'h0000_7777);
    idle(10);
    chk_eq("R7", "no send without credit", 64'(log_n), 64'd0);
    ret(4'b0100);
    chk_eq("R7", "not yet after credit", 64'(out_valid), 64'd0);
    idle(1);
    chk_eq("R7", "sent after credit", 64'(out_valid), 64'd1);
    chk_eq("R7", "credit flit data", 64'(out_data), 64'h0000_7777);
    idle(2);
    log_n = 0;

    // R3 and R4: fill a stalled channel, overflow, order
    do_reset();
    drain(1);
    for (int i = 0; i < DEP; i++)
      push(1, i == 0, i == DEP - 1, 32'h100 + 32'(i));
    chk_eq("R3", "in_ready when full", 64'(in_ready), 64'b1101);
    chk_eq("R3", "no overflow yet", 64'(overflow), 64'd0);
    push(1, 1'b1, 1'b1, 32'h104);
    chk_eq("R3", "overflow set", 64'(overflow), 64'b0010);
    for (int i = 0; i < DEP; i++) begin
      ret(4'b0010);
      idle(1);
    end
    idle(3);
    chk_eq("R4", "flit count", 64'(log_n), 64'(DEP));
    for (int i = 0; i < DEP; i++)
      chk_eq("R4", "order", 64'(log_d[i]), 64'(32'h100 + 32'(i)));
    ret(4'b0010);
    idle(4);
    chk_eq("R3", "dropped flit never sent", 64'(log_n), 64'(DEP));
    chk_eq("R3", "overflow sticky", 64'(overflow), 64'b0010);
    chk_eq("R3", "ready after drain", 64'(in_ready), 64'hF);

    // R5: fixed priority among stalled channels
    do_reset();
    for (int v = 0; v < NV; v++) drain(v);
    push(3, 1'b1, 1'b1, 32'hD3);
    push(1, 1'b1, 1'b1, 32'hD1);
    push(0, 1'b1, 1'b1, 32'hD0);
    push(2, 1'b1, 1'b1, 32'hD2);
    ret(4'b1111);
    idle(6);
    chk_eq("R5", "count", 64'(log_n), 64'd4);
    for (int i = 0; i < NV; i++) begin
      chk_eq("R5", "order vc", 64'(log_vc[i]), 64'(i));
      chk_eq("R5", "order data", 64'(log_d[i]), 64'(32'hD0 + 32'(i)));
    end

    // R6: a packet owns the link from first to last flit
    do_reset();
    drain(0);
    drain(1);
    push(1, 1'b1, 1'b0, 32'hB0);
    push(1, 1'b0, 1'b0, 32'hB1);
    push(1, 1'b0, 1'b1, 32'hB2);
    push(0, 1'b1, 1'b1, 32'hC0);
    ret(4'b0010);
    idle(3);
    chk_eq("R6", "first flit sent", 64'(log_n), 64'd1);
    chk_eq("R6", "first flit vc", 64'(log_vc[0]), 64'd1);
    ret(4'b0001);
    idle(4);
    chk_eq("R6", "higher priority held off", 64'(log_n), 64'd1);
    ret(4'b0010);
    ret(4'b0010);
    idle(4);
    chk_eq("R6", "count", 64'(log_n), 64'd4);
    chk_eq("R6", "body", 64'(log_d[1]), 64'hB1);
    chk_eq("R6", "tail", 64'({log_d[2], log_t[2]}), 64'({32'hB2, 1'b1}));
    chk_eq("R6", "waiting channel last", 64'(log_d[3]), 64'hC0);

    // R8: a whole-packet flit does not hold the link
    do_reset();
    drain(0);
    drain(1);
    push(1, 1'b1, 1'b1, 32'hE1);
    push(0, 1'b1, 1'b1, 32'hE0);
    ret(4'b0010);
    idle(3);
    chk_eq("R8", "single flit sent", 64'(log_n), 64'd1);
    ret(4'b0001);
    idle(3);
    chk_eq("R8", "next channel free", 64'(log_n), 64'd2);
    chk_eq("R8", "next channel data", 64'(log_d[1]), 64'hE0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule